// File: doc/BRIEF.md
# Fine-Grained Multithreading Thread Selector

This block sits in the thread-select stage of a single-issue, in-order core that holds four hardware thread contexts. On every clock cycle it chooses one thread to issue and moves on to a different ready thread on the next cycle. It does not stay with one thread until that thread hits a long-latency event. Threads that cannot issue are skipped. A thread cannot issue while it is disabled, while it is serving a fixed load or branch delay, or while it is waiting on an outstanding cache miss. The core issues nothing only in a cycle where every thread is blocked.

The pipeline reports back on the chosen thread in the same cycle. It raises an issue-event flag and gives the event type (load, branch or other). A load or a branch locks its thread out for the next three cycles, and only the other threads can fill those slots. The cache side sends a per-thread miss-begin pulse and a per-thread fill-complete pulse. A thread with an open miss waits for its fill, however long that takes. The short delay count and the miss flag are kept apart, and a thread is ready only when both are clear.

Top module: `mt_thread_picker`

## Requirements
- R1: `issueValid` is high in a cycle exactly when at least one bit of `threadReady` is high; with all four threads blocked, it is low.
- R2: The granted thread is the first ready thread found when searching upward, with wrap-around, from the thread after the one that last issued. Consecutive grants therefore rotate among the ready threads.
- R3: `threadReady[i]` is high exactly when `thrValid[i]` is high, thread i has no pending fixed delay, and thread i has no open miss.
- R4: When the selected thread issues with `issueEvt` high and `evtType` = 2'b01 (load) or 2'b10 (branch), that thread is not ready in the next three cycles. It becomes ready again in the fourth cycle if nothing else blocks it.
- R5: An `evtType` of 2'b00 (other) or 2'b11 (reserved) adds no delay.
- R6: A pulse on `missBegin[i]` makes thread i not ready from the next cycle onward. It stays not ready until the cycle after a pulse on `fillDone[i]`, with no time limit. When both pulses arrive in the same cycle, the miss stays open.
- R7: The delay count and the miss flag are tracked separately. A thread whose fill arrives during its delay is still blocked until the delay ends, and the reverse also holds.
- R8: `issueEvt` has no effect in a cycle where `issueValid` is low.
- R9: Synchronous active-high `rst` clears all delays and misses and points the search at thread 0. The first grant after reset therefore goes to the lowest ready thread.
- R10: A thread whose `thrValid` bit is low is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| thrValid | input | 4 | Per-thread enable; low means the context holds no work |
| issueEvt | input | 1 | The thread granted this cycle issued an instruction |
| evtType | input | 2 | Type of that instruction: 00 other, 01 load, 10 branch, 11 reserved (other) |
| missBegin | input | 4 | Per-thread pulse: a cache miss has opened |
| fillDone | input | 4 | Per-thread pulse: the outstanding miss has been filled |
| selThread | output | 2 | Granted thread number (meaningful when issueValid is high) |
| issueValid | output | 1 | A thread is granted this cycle |
| threadReady | output | 4 | Per-thread ready status |

## Verification
The bench first walks through all sixteen valid-flag patterns with every thread issuing loads, branches and plain instructions. This shows that rotation order and skipping of disabled threads do not depend on which threads exist. Directed runs then isolate single effects. One lone thread issues a load, to measure the exact three-cycle gap. An event is offered with nothing granted, to show it is ignored. A miss is held open for dozens of cycles, to tell an open-ended wait from a fixed one. A fill lands inside a delay, and begin and fill pulses coincide, which separates the two stall sources and sets the pulse priority. A long pseudo-random run of misses, fills and event types follows, in which every thread is at times blocked together. Each cycle is compared against an arithmetic model of pointer, counters and flags built in the bench.

// File: rtl/ftsel_pkg.sv
package ftsel_pkg;
  localparam int unsigned THREAD_CNT = 4;
  localparam int unsigned FIXED_DELAY = 3;
  localparam int unsigned ID_W = (THREAD_CNT > 1) ? $clog2(THREAD_CNT) : 1;
  localparam int unsigned CNT_W = $clog2(FIXED_DELAY + 1);

  typedef enum logic [1:0] {
    EV_OTHER  = 2'b00,
    EV_LOAD   = 2'b01,
    EV_BRANCH = 2'b10,
    EV_RSVD   = 2'b11
  } evt_e;

  // strobes from control to the per-thread state
  typedef struct packed {
    logic                  issue;
    logic [THREAD_CNT-1:0] grantOh;
    logic                  armDelay;
  } strobe_t;
endpackage

// File: rtl/ftsel_ctrl.sv
module ftsel_ctrl
  import ftsel_pkg::*;
#(
  parameter int unsigned NT  = THREAD_CNT,
  parameter int unsigned IDW = ID_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NT-1:0]  readyVec,
  input  logic           issueEvt,
  input  logic [1:0]     evtType,
  output strobe_t        strobe,
  output logic [IDW-1:0] selId,
  output logic           issueValid
);
  logic [IDW-1:0] searchPtr;
  logic [IDW-1:0] grantId;
  logic           found;
  logic           longEvt;

  // rotating priority search starting at searchPtr
  always_comb begin
    found   = 1'b0;
    grantId = '0;
    for (int k = 0; k < int'(NT); k++) begin
      int idx;
      idx = int'(searchPtr) + k;
      if (idx >= int'(NT)) idx = idx - int'(NT);
      if (!found && readyVec[idx]) begin
        found   = 1'b1;
        grantId = IDW'(idx);
      end
    end
  end

  assign longEvt    = (evtType == EV_LOAD) || (evtType == EV_BRANCH);
  assign selId      = grantId;
  assign issueValid = found;

  always_comb begin
    strobe          = '0;
    strobe.issue    = found;
    if (found) strobe.grantOh[grantId] = 1'b1;
    strobe.armDelay = found && issueEvt && longEvt;
  end

  always_ff @(posedge clk) begin
    if (rst) searchPtr <= '0;
    else if (found) begin
      if (grantId == IDW'(NT - 1)) searchPtr <= '0;
      else                         searchPtr <= grantId + 1'b1;
    end
  end

  assert_grant_ready_R10: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> readyVec[selId]);
  assert_idle_all_blocked_R1: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> (readyVec == '0));
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe.grantOh));
  assert_no_arm_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> !strobe.armDelay);
endmodule

// File: rtl/ftsel_dp.sv
module ftsel_dp
  import ftsel_pkg::*;
#(
  parameter int unsigned NT   = THREAD_CNT,
  parameter int unsigned DLY  = FIXED_DELAY,
  parameter int unsigned CW   = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] thrValid,
  input  strobe_t       strobe,
  input  logic [NT-1:0] missBegin,
  input  logic [NT-1:0] fillDone,
  output logic [NT-1:0] readyVec
);
  for (genvar g = 0; g < NT; g++) begin : gThread
    logic [CW-1:0] delayCnt;
    logic          missOpen;

    always_ff @(posedge clk) begin
      if (rst)                                        delayCnt <= '0;
      else if (strobe.armDelay && strobe.grantOh[g])  delayCnt <= CW'(DLY);
      else if (delayCnt != '0)                        delayCnt <= delayCnt - 1'b1;
    end

    // a new miss wins over a fill in the same cycle
    always_ff @(posedge clk) begin
      if (rst)               missOpen <= 1'b0;
      else if (missBegin[g]) missOpen <= 1'b1;
      else if (fillDone[g])  missOpen <= 1'b0;
    end

    assign readyVec[g] = thrValid[g] && (delayCnt == '0) && !missOpen;

    assert_delay_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      (strobe.armDelay && strobe.grantOh[g]) |=> !readyVec[g]);
    assert_miss_holds_R6: assert property (@(posedge clk) disable iff (rst)
      (missOpen && !fillDone[g]) |=> !readyVec[g]);
    assert_begin_blocks_R6: assert property (@(posedge clk) disable iff (rst)
      missBegin[g] |=> !readyVec[g]);
    assert_delay_counts_down_R7: assert property (@(posedge clk) disable iff (rst)
      (delayCnt > 1 && !strobe.grantOh[g]) |=> !readyVec[g]);
  end
endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker
  import ftsel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [THREAD_CNT-1:0] thrValid,
  input  logic                  issueEvt,
  input  logic [1:0]            evtType,
  input  logic [THREAD_CNT-1:0] missBegin,
  input  logic [THREAD_CNT-1:0] fillDone,
  output logic [ID_W-1:0]       selThread,
  output logic                  issueValid,
  output logic [THREAD_CNT-1:0] threadReady
);
  strobe_t               strobe;
  logic [THREAD_CNT-1:0] readyVec;

  ftsel_ctrl #(.NT(THREAD_CNT), .IDW(ID_W)) i_ctrl (
    .clk(clk), .rst(rst), .readyVec(readyVec), .issueEvt(issueEvt),
    .evtType(evtType), .strobe(strobe), .selId(selThread),
    .issueValid(issueValid)
  );

  ftsel_dp #(.NT(THREAD_CNT), .DLY(FIXED_DELAY), .CW(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .thrValid(thrValid), .strobe(strobe),
    .missBegin(missBegin), .fillDone(fillDone), .readyVec(readyVec)
  );

  assign threadReady = readyVec;
endmodule

// File: tb/test_mt_thread_picker.sv
`timescale 1ns/1ps
module test_mt_thread_picker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] thrValid = 4'h0;
  logic       issueEvt = 1'b0;
  logic [1:0] evtType = 2'b00;
  logic [3:0] missBegin = 4'h0;
  logic [3:0] fillDone = 4'h0;
  logic [1:0] selThread;
  logic       issueValid;
  logic [3:0] threadReady;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int mCnt[4];
  bit mMiss[4];
  int mPtr = 0;
  bit expValid;
  int expSel;
  logic [3:0] expReady;

  always #5 clk = ~clk;

  mt_thread_picker i_mt_thread_picker (
    .clk(clk), .rst(rst), .thrValid(thrValid), .issueEvt(issueEvt),
    .evtType(evtType), .missBegin(missBegin), .fillDone(fillDone),
    .selThread(selThread), .issueValid(issueValid), .threadReady(threadReady)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin mCnt[i] = 0; mMiss[i] = 1'b0; end
    mPtr = 0;
  endtask

  function automatic void predict();
    expValid = 1'b0;
    expSel = 0;
    for (int i = 0; i < 4; i++)
      expReady[i] = thrValid[i] && (mCnt[i] == 0) && !mMiss[i];
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = (mPtr + k) % 4;
      if (!expValid && expReady[idx]) begin expValid = 1'b1; expSel = idx; end
    end
  endfunction

  // inputs already applied after a falling edge; compare, then advance one clock
  task automatic step(string readyTag);
    #1;
    predict();
    check(readyTag, threadReady, expReady);
    check("R1", issueValid, expValid);
    if (expValid) begin
      check("R2", selThread, expSel);
      check("R10", thrValid[selThread], 1);
    end
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (mCnt[i] > 0) mCnt[i]--;
      if (expValid && issueEvt && expSel == i && (evtType == 2'b01 || evtType == 2'b10))
        mCnt[i] = 3;
      if (missBegin[i]) mMiss[i] = 1'b1;
      else if (fillDone[i]) mMiss[i] = 1'b0;
    end
    if (expValid) mPtr = (expSel + 1) % 4;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  initial begin
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    thrValid = 4'hF;

    // R9: reset state
    #1;
    check("R9", threadReady, 4'hF);
    check("R9", selThread, 0);
    step("R9");

    // exhaustive valid patterns with mixed event types
    for (int v = 0; v < 16; v++) begin
      doReset();
      thrValid = 4'(v);
      for (int c = 0; c < 24; c++) begin
        issueEvt = (c % 3) != 2;
        evtType  = 2'(c % 4);
        step((c % 4 == 1 || c % 4 == 2) ? "R4" : "R5");
      end
    end

    // R4: lone thread load gap, literal expectations
    doReset();
    thrValid = 4'b0010; issueEvt = 1'b1; evtType = 2'b01;
    #1;
    check("R4", selThread, 1);
    step("R4");
    issueEvt = 1'b0;
    for (int c = 0; c < 3; c++) begin
      #1; check("R4", threadReady[1], 0);
      step("R4");
    end
    #1; check("R4", threadReady[1], 1);
    step("R4");

    // R8: event with nothing granted is ignored
    doReset();
    thrValid = 4'b0000; issueEvt = 1'b1; evtType = 2'b10;
    step("R8");
    thrValid = 4'b0001; issueEvt = 1'b0;
    #1; check("R8", threadReady[0], 1);
    step("R8");

    // R6: long miss wait, then coincident begin/fill
    doReset();
    thrValid = 4'hF; issueEvt = 1'b0;
    missBegin = 4'b0100;
    step("R6");
    missBegin = 4'b0000;
    for (int c = 0; c < 40; c++) begin
      #1; check("R6", threadReady[2], 0);
      step("R6");
    end
    missBegin = 4'b0100; fillDone = 4'b0100;
    step("R6");
    missBegin = 4'b0000; fillDone = 4'b0000;
    #1; check("R6", threadReady[2], 0);
    fillDone = 4'b0100;
    step("R6");
    fillDone = 4'b0000;
    #1; check("R6", threadReady[2], 1);
    step("R6");

    // R7: fill during a delay keeps the thread blocked until the delay ends
    doReset();
    thrValid = 4'b0001; issueEvt = 1'b1; evtType = 2'b10; missBegin = 4'b0001;
    step("R7");
    issueEvt = 1'b0; missBegin = 4'b0000; fillDone = 4'b0001;
    step("R7");
    fillDone = 4'b0000;
    #1; check("R7", threadReady[0], 0);
    step("R7");
    #1; check("R7", threadReady[0], 0);
    step("R7");
    #1; check("R7", threadReady[0], 1);
    step("R7");

    // pseudo-random mix of misses, fills and events
    doReset();
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom);
      thrValid  = ((r & 63) == 0) ? 4'(r >> 6) : 4'hF;
      issueEvt  = r[8];
      evtType   = 2'(r >> 9);
      missBegin = ((r >> 11) % 5 == 0) ? 4'(r >> 14) : 4'h0;
      fillDone  = 4'(r >> 18) & 4'(r >> 22);
      step("R3");
    end
    missBegin = 4'h0; fillDone = 4'h0; issueEvt = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule